// File: doc/BRIEF.md
# Key-Protected Power Control Register

This block is a 32-bit control word inside a converter's configuration space, reached one byte at a time. Its low byte holds two alarm-disable bits, the reset-pin mode bit, the nap enable and the power-down bit. None of these can change unless an 8-bit key byte, held in the next byte up, already contains the unlock value. The two upper bytes are reserved.

The block also reads the external reset pin. A rising edge on the pin starts either a full power-on-class initialization or an application reset, depending on the stored mode bit. A full initialization clears every bit and raises a one-cycle full-init request. An application reset clears only the user settings: the key, the alarm disables and power-down. It keeps the mode bit and the nap enable, and raises a one-cycle application-clear request. The block also tracks a nap state from the conversion-done and chip-select/convert-start inputs.

Top module: `pkc_power_ctrl`

## Requirements
- R1: Byte reads are combinational. BASE_ADDR (default 04h) returns {2'b00, supply_alarm_off, input_alarm_off, 1'b0, pin_app_mode, nap_enable, power_down}. BASE_ADDR+1 returns the key. BASE_ADDR+2, BASE_ADDR+3 and any address outside the window return 00h.
- R2: The key byte at BASE_ADDR+1 is written whole by a write to that address and reads back 00h after reset.
- R3: A write to BASE_ADDR updates bits 5, 4, 2, 1 and 0 from wdata only if the key held KEY_VALUE (default 69h) before that write's clock edge. Otherwise the write leaves the low byte unchanged.
- R4: Reserved bits (7, 6 and 3 of the low byte, and both upper bytes) always read 0, and writes to them have no effect.
- R5: Outputs supply_alarm_off, input_alarm_off, pin_app_mode, nap_enable and power_down follow low-byte bits 5, 4, 2, 1 and 0.
- R6: A synchronous power-on reset (rst high) clears all bits, the key, the nap state and both request outputs.
- R7: A pin rising edge while pin_app_mode is 0 clears every bit and the key at that clock edge, and raises full_init_req for exactly the next cycle.
- R8: A pin rising edge while pin_app_mode is 1 clears the key, bits 5, 4 and 0 and the nap state, keeps bits 2 and 1, and raises app_clear_req for one cycle.
- R9: With nap_enable 1 and power_down 0, conv_done high while cs_convst is high sets nap_active at the next edge.
- R10: nap_active clears one edge after a falling edge of cs_convst, and stays low on any edge that follows a cycle in which power_down is 1.
- R11: A pin held high gives one request only, and the two request outputs are never high together.
- R12: A pin edge takes priority over a register write in the same cycle, and that write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| reg_addr | input | ADDR_W | Byte address |
| reg_wr | input | 1 | Byte write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ext_rst_pin | input | 1 | External reset pin, active high |
| conv_done | input | 1 | Conversion finished this cycle |
| cs_convst | input | 1 | Chip-select / convert-start level |
| supply_alarm_off | output | 1 | Supply alarm disabled |
| input_alarm_off | output | 1 | Input alarm disabled |
| pin_app_mode | output | 1 | Pin performs application reset |
| nap_enable | output | 1 | Nap mode allowed |
| power_down | output | 1 | Converter powered down |
| nap_active | output | 1 | Converter is in nap |
| full_init_req | output | 1 | One-cycle full initialization request |
| app_clear_req | output | 1 | One-cycle application-clear request |

## Verification
The bench builds the block with its defaults: an 8-bit address, a window based at 04h and unlock value 69h. With these values, writes and reads can reach all four bytes of the window and addresses 00h and 08h just outside it. The sequence steps through locked writes, unlocked writes, relocking, both kinds of pin reset (including a pin held high and a pin edge that coincides with a write), and nap entry and exit, with power-down blocking nap.

// File: rtl/pkc_pkg.sv
`timescale 1ns/1ps
package pkc_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic supply_al_off;
        logic input_al_off;
        logic app_rst_mode;
        logic nap_en;
        logic pwr_down;
    } ctl_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_FULL = 2'd1,
        EV_APP  = 2'd2
    } rst_ev_t;

    typedef enum logic {
        NAP_AWAKE  = 1'b0,
        NAP_ASLEEP = 1'b1
    } nap_st_t;

    function automatic byte_t pack_low(ctl_t c);
        return {2'b00, c.supply_al_off, c.input_al_off, 1'b0,
                c.app_rst_mode, c.nap_en, c.pwr_down};
    endfunction

endpackage

// File: rtl/pkc_rst_ctl.sv
`timescale 1ns/1ps
module pkc_rst_ctl
    import pkc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pin,
    input  logic    app_mode,
    output rst_ev_t ev,
    output logic    full_pulse,
    output logic    app_pulse
);
    logic pin_prev;
    logic pin_edge;

    assign pin_edge = pin && !pin_prev;

    always_comb begin
        if (!pin_edge)     ev = EV_NONE;
        else if (app_mode) ev = EV_APP;
        else               ev = EV_FULL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev   <= 1'b1;
            full_pulse <= 1'b0;
            app_pulse  <= 1'b0;
        end else begin
            pin_prev   <= pin;
            full_pulse <= (ev == EV_FULL);
            app_pulse  <= (ev == EV_APP);
        end
    end

    p_one_kind_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({full_pulse, app_pulse}));
    p_full_single_r11: assert property (@(posedge clk) disable iff (rst)
        full_pulse |=> !full_pulse);
    p_app_single_r11: assert property (@(posedge clk) disable iff (rst)
        app_pulse |=> !app_pulse);

endmodule

// File: rtl/pkc_nap_fsm.sv
`timescale 1ns/1ps
module pkc_nap_fsm
    import pkc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rst_ev_t ev,
    input  logic    nap_en,
    input  logic    pwr_down,
    input  logic    conv_done,
    input  logic    cs,
    output logic    nap_active
);
    nap_st_t state;
    logic    cs_prev;
    logic    cs_fall;

    assign cs_fall    = cs_prev && !cs;
    assign nap_active = (state == NAP_ASLEEP);

    always_ff @(posedge clk) begin
        if (rst || ev != EV_NONE) begin
            state   <= NAP_AWAKE;
            cs_prev <= rst ? 1'b0 : cs;
        end else begin
            cs_prev <= cs;
            if (pwr_down || cs_fall)
                state <= NAP_AWAKE;
            else if (nap_en && conv_done && cs)
                state <= NAP_ASLEEP;
        end
    end

    p_pd_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> !nap_active);
    p_cs_exit_r10: assert property (@(posedge clk) disable iff (rst)
        (nap_active && cs_fall) |=> !nap_active);

endmodule

// File: rtl/pkc_cfg_regs.sv
`timescale 1ns/1ps
module pkc_cfg_regs
    import pkc_pkg::*;
#(
    parameter int    ADDR_W    = 8,
    parameter int    BASE_ADDR = 4,
    parameter byte_t KEY_VALUE = 8'h69
) (
    input  logic              clk,
    input  logic              rst,
    input  rst_ev_t           ev,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  byte_t             wdata,
    output byte_t             rdata,
    output ctl_t              ctl,
    output byte_t             key
);
    localparam logic [ADDR_W-1:0] A_LOW = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(BASE_ADDR + 1);

    logic  unlocked;
    ctl_t  ctl_wr;

    assign unlocked = (key == KEY_VALUE);
    assign ctl_wr   = '{supply_al_off: wdata[5], input_al_off: wdata[4],
                        app_rst_mode: wdata[2], nap_en: wdata[1],
                        pwr_down: wdata[0]};

    always_ff @(posedge clk) begin
        if (rst || ev == EV_FULL) begin
            key <= '0;
            ctl <= '0;
        end else if (ev == EV_APP) begin
            key               <= '0;
            ctl.supply_al_off <= 1'b0;
            ctl.input_al_off  <= 1'b0;
            ctl.pwr_down      <= 1'b0;
        end else if (wr) begin
            if (addr == A_KEY)
                key <= wdata;
            if (addr == A_LOW && unlocked)
                ctl <= ctl_wr;
        end
    end

    always_comb begin
        if (addr == A_LOW)      rdata = pack_low(ctl);
        else if (addr == A_KEY) rdata = key;
        else                    rdata = '0;
    end

    p_locked_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_LOW && !unlocked && ev == EV_NONE) |=> $stable(ctl));
    p_key_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_KEY && ev == EV_NONE) |=> key == $past(wdata));
    p_app_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_APP) |=> (ctl.app_rst_mode && ctl.nap_en == $past(ctl.nap_en)
                            && key == '0 && !ctl.pwr_down));
    p_full_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_FULL) |=> (ctl == '0 && key == '0));

endmodule

// File: rtl/pkc_power_ctrl.sv
`timescale 1ns/1ps
module pkc_power_ctrl
    import pkc_pkg::*;
#(
    parameter int    ADDR_W    = 8,
    parameter int    BASE_ADDR = 4,
    parameter byte_t KEY_VALUE = 8'h69
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ext_rst_pin,
    input  logic              conv_done,
    input  logic              cs_convst,
    output logic              supply_alarm_off,
    output logic              input_alarm_off,
    output logic              pin_app_mode,
    output logic              nap_enable,
    output logic              power_down,
    output logic              nap_active,
    output logic              full_init_req,
    output logic              app_clear_req
);
    rst_ev_t ev;
    ctl_t    ctl;
    byte_t   key;

    pkc_rst_ctl u_rst (
        .clk        (clk),
        .rst        (rst),
        .pin        (ext_rst_pin),
        .app_mode   (ctl.app_rst_mode),
        .ev         (ev),
        .full_pulse (full_init_req),
        .app_pulse  (app_clear_req)
    );

    pkc_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .KEY_VALUE (KEY_VALUE)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .addr  (reg_addr),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctl   (ctl),
        .key   (key)
    );

    pkc_nap_fsm u_nap (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .nap_en     (ctl.nap_en),
        .pwr_down   (ctl.pwr_down),
        .conv_done  (conv_done),
        .cs         (cs_convst),
        .nap_active (nap_active)
    );

    assign supply_alarm_off = ctl.supply_al_off;
    assign input_alarm_off  = ctl.input_al_off;
    assign pin_app_mode     = ctl.app_rst_mode;
    assign nap_enable       = ctl.nap_en;
    assign power_down       = ctl.pwr_down;

    p_req_after_edge_r7: assert property (@(posedge clk) disable iff (rst)
        full_init_req |-> (key == '0 && ctl == '0));

endmodule

// File: tb/tb_pkc_power_ctrl.sv
`timescale 1ns/1ps
module tb_pkc_power_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       ext_rst_pin;
    logic       conv_done;
    logic       cs_convst;
    logic       supply_alarm_off, input_alarm_off, pin_app_mode;
    logic       nap_enable, power_down, nap_active;
    logic       full_init_req, app_clear_req;

    always #2.5 clk = ~clk;

    pkc_power_ctrl dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_rst_pin(ext_rst_pin),
        .conv_done(conv_done), .cs_convst(cs_convst),
        .supply_alarm_off(supply_alarm_off), .input_alarm_off(input_alarm_off),
        .pin_app_mode(pin_app_mode), .nap_enable(nap_enable),
        .power_down(power_down), .nap_active(nap_active),
        .full_init_req(full_init_req), .app_clear_req(app_clear_req)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit       m_b5, m_b4, m_b2, m_b1, m_b0, m_nap, m_pp, m_cp, m_fi, m_ac;
    bit [7:0] m_key;

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit [7:0] m_read(logic [7:0] a);
        if (a == 8'h04) return {2'b00, m_b5, m_b4, 1'b0, m_b2, m_b1, m_b0};
        if (a == 8'h05) return m_key;
        return 8'h00;
    endfunction

    task automatic model(bit r, logic [7:0] a, bit w, logic [7:0] d, bit p, bit dn, bit c);
        bit pe;
        bit nap_n;
        pe = p && !m_pp;
        if (r || pe)              nap_n = 0;
        else if (m_b0)            nap_n = 0;
        else if (m_cp && !c)      nap_n = 0;
        else if (m_b1 && dn && c) nap_n = 1;
        else                      nap_n = m_nap;
        m_fi = 0;
        m_ac = 0;
        if (r) begin
            {m_b5, m_b4, m_b2, m_b1, m_b0} = '0; m_key = 0; m_pp = 1; m_cp = 0;
        end else begin
            if (pe && !m_b2) begin
                {m_b5, m_b4, m_b2, m_b1, m_b0} = '0; m_key = 0; m_fi = 1;
            end else if (pe) begin
                m_b5 = 0; m_b4 = 0; m_b0 = 0; m_key = 0; m_ac = 1;
            end else if (w) begin
                if (a == 8'h04 && m_key == 8'h69)
                    {m_b5, m_b4, m_b2, m_b1, m_b0} = {d[5], d[4], d[2], d[1], d[0]};
                if (a == 8'h05) m_key = d;
            end
            m_pp = p;
            m_cp = c;
        end
        m_nap = nap_n;
    endtask

    task automatic step(bit r, logic [7:0] a, bit w, logic [7:0] d, bit p, bit dn, bit c);
        @(negedge clk);
        rst = r; reg_addr = a; reg_wr = w; reg_wdata = d;
        ext_rst_pin = p; conv_done = dn; cs_convst = c;
        model(r, a, w, d, p, dn, c);
        @(posedge clk);
        #1;
        chk("R5", "ctl outputs",
            {3'b0, supply_alarm_off, input_alarm_off, pin_app_mode, nap_enable, power_down},
            {3'b0, m_b5, m_b4, m_b2, m_b1, m_b0});
        chk("R9", "nap_active", {7'b0, nap_active}, {7'b0, m_nap});
        chk("R7", "full_init_req", {7'b0, full_init_req}, {7'b0, m_fi});
        chk("R8", "app_clear_req", {7'b0, app_clear_req}, {7'b0, m_ac});
        chk("R1", "rdata", reg_rdata, m_read(a));
    endtask

    task automatic peek(string tag, logic [7:0] a, logic [7:0] exp);
        reg_addr = a;
        #0.3;
        chk(tag, "readback", reg_rdata, exp);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        step(0, a, 1, d, ext_rst_pin, 0, cs_convst);
    endtask

    task automatic idle(bit p, bit dn, bit c);
        step(0, 8'h04, 0, 8'h00, p, dn, c);
    endtask

    initial begin
        rst = 1; reg_addr = 0; reg_wr = 0; reg_wdata = 0;
        ext_rst_pin = 0; conv_done = 0; cs_convst = 0;
        step(1, 8'h04, 0, 0, 0, 0, 0);
        step(1, 8'h04, 0, 0, 0, 0, 0);
        peek("R6", 8'h04, 8'h00);
        peek("R2", 8'h05, 8'h00);
        idle(0, 0, 0);

        wr(8'h04, 8'h37);
        peek("R3", 8'h04, 8'h00);
        wr(8'h05, 8'h68);
        wr(8'h04, 8'h37);
        peek("R3", 8'h04, 8'h00);

        wr(8'h05, 8'h69);
        peek("R2", 8'h05, 8'h69);
        wr(8'h04, 8'hFF);
        peek("R4", 8'h04, 8'h37);
        wr(8'h06, 8'hFF);
        wr(8'h07, 8'hFF);
        peek("R4", 8'h06, 8'h00);
        peek("R4", 8'h07, 8'h00);
        peek("R1", 8'h08, 8'h00);
        peek("R1", 8'h00, 8'h00);

        idle(0, 1, 1);
        chk("R10", "no nap in power-down", {7'b0, nap_active}, 8'h00);
        wr(8'h05, 8'h00);
        wr(8'h04, 8'h00);
        peek("R3", 8'h04, 8'h37);

        wr(8'h05, 8'h69);
        wr(8'h04, 8'h06);
        idle(0, 0, 1);
        idle(0, 1, 1);
        chk("R9", "nap entered", {7'b0, nap_active}, 8'h01);
        idle(0, 0, 1);
        idle(0, 0, 0);
        chk("R10", "nap left on cs fall", {7'b0, nap_active}, 8'h00);

        idle(0, 0, 1);
        idle(0, 1, 1);
        wr(8'h04, 8'h36);
        idle(0, 0, 1);
        idle(1, 0, 1);
        chk("R8", "app reset kept mode/nap bits", {7'b0, app_clear_req}, 8'h01);
        peek("R8", 8'h04, 8'h06);
        peek("R8", 8'h05, 8'h00);
        idle(1, 0, 1);
        chk("R11", "held pin no repeat", {6'b0, app_clear_req, full_init_req}, 8'h00);
        idle(1, 0, 1);
        idle(0, 0, 0);

        wr(8'h05, 8'h69);
        step(0, 8'h04, 1, 8'h01, 1, 0, 0);
        chk("R12", "write dropped on pin edge", {7'b0, power_down}, 8'h00);
        peek("R12", 8'h04, 8'h06);
        idle(0, 0, 0);

        wr(8'h05, 8'h69);
        wr(8'h04, 8'h31);
        idle(0, 0, 0);
        idle(1, 0, 0);
        chk("R7", "full init pulse", {7'b0, full_init_req}, 8'h01);
        peek("R7", 8'h04, 8'h00);
        peek("R7", 8'h05, 8'h00);
        idle(1, 0, 0);
        chk("R7", "pulse one cycle", {7'b0, full_init_req}, 8'h00);
        idle(0, 0, 0);

        wr(8'h05, 8'h69);
        wr(8'h04, 8'h35);
        step(1, 8'h04, 0, 0, 0, 0, 0);
        peek("R6", 8'h04, 8'h00);
        peek("R6", 8'h05, 8'h00);
        idle(0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule